// File: doc/BRIEF.md
# Banked Boot Memory with Byte-Lane Gating

This block is a small read-mostly memory for a processor's boot path. Several banks of 32-bit words sit side by side on one 32-bit read bus. A byte address and a size code (byte, halfword or word) are decoded into two things. The high address bits give a one-hot bank select. The two lowest bits, together with the size code, give a set of byte-lane enables. Each byte lane of each bank has its own drive enable, which is the AND of its bank select and its lane enable. The read bus is the AND-OR merge of all gated lanes, so no wide word multiplexer is needed.

Reads are combinational from address, size and the read strobe, in the manner of a distributed memory with no output register. Each bank resets to a fixed table computed inside the design. With the `WRITABLE` parameter set, the block is a RAM. On a clock edge, a write stores only the enabled byte lanes of the selected bank.

A misaligned halfword or word access, or an access with the reserved size code, raises an error flag. Such an access drives no lane and writes nothing. Byte data always stays in its natural lane position on the bus; nothing is shifted.

Top module: `bootmem_banked`

## Requirements
- R1: Address bits [7:6] pick one of four banks and bits [5:2] pick one of 16 words; the same word index applies in every bank.
- R2: Size code 00 (byte) enables only lane addr[1:0]; lane k carries data bits [8k+7:8k].
- R3: Size code 01 (halfword) enables lanes 1 and 0 when addr[1] is 0, and lanes 3 and 2 when addr[1] is 1; addr[0]=1 is misaligned.
- R4: Size code 10 (word) enables all four lanes when addr[1:0] is 00; any other offset is misaligned.
- R5: Size code 11 is reserved and is always treated as an error.
- R6: `err` is 1 exactly when `rd_en` or `wr_en` is high and the access is misaligned or reserved; while `err` is 1, `bus_drive` and `rdata` are all zero.
- R7: On a good read, enabled lanes show the stored bytes in their natural positions, and lanes that are not enabled read zero.
- R8: With `rd_en` low, `rdata` and `bus_drive` are zero whatever the address and size.
- R9: `bus_drive[4*b+k]` is the drive enable of bank b, lane k; for each lane, at most one bank drives.
- R10: After reset, the byte at byte address a holds the value a[7:0].
- R11: With `wr_en` high and no error, the rising clock edge writes the enabled lanes of the selected bank from the same lanes of `wdata`; all other bytes keep their values, and an erroneous write changes nothing.
- R12: Asserting reset again restores the whole memory to the table of R10.
- R13: Read data follows address and size in the same cycle, and data written at an edge is readable in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write port |
| rst_n | input | 1 | Active-low reset; reloads the initial table |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte address |
| size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| wdata | input | 32 | Write data, in natural lane positions |
| rdata | output | 32 | Merged read bus |
| err | output | 1 | Misaligned or reserved access |
| bus_drive | output | 16 | Per-bank, per-lane drive enables |

## Verification
The hardest case to reach from the ports is a partial write that must leave its neighbours alone. The other lanes of the same word, the same word in the other banks, and every target of a rejected misaligned write must all stay unchanged. To reach it, the stimulus runs a series of writes that mixes the three sizes, several offsets, misaligned forms and the reserved code across all banks. A byte-level model in the bench follows the same series. After it, the bench reads back every word and compares it with the model. Before that, the bench sweeps every address against every size code, reading all drive enables and bus lanes.

// File: rtl/bootmem_pkg.sv
package bootmem_pkg;
    localparam int LANES = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;
endpackage

// File: rtl/bootmem_lane_dec.sv
module bootmem_lane_dec
    import bootmem_pkg::*;
(
    input  logic [1:0]       offs,
    input  logic [1:0]       size,
    output logic [LANES-1:0] lane_en,
    output logic             misal
);
    always_comb begin
        lane_en = '0;
        misal   = 1'b0;
        unique case (acc_size_e'(size))
            SZ_BYTE: lane_en = 4'b0001 << offs;
            SZ_HALF: begin
                if (offs[0]) misal = 1'b1;
                else         lane_en = offs[1] ? 4'b1100 : 4'b0011;
            end
            SZ_WORD: begin
                if (offs != 2'b00) misal = 1'b1;
                else               lane_en = 4'b1111;
            end
            default: misal = 1'b1;
        endcase
    end
endmodule

// File: rtl/bootmem_bank.sv
module bootmem_bank
    import bootmem_pkg::*;
#(
    parameter int BANK_ID  = 0,
    parameter int WORDS    = 16,
    parameter bit WRITABLE = 1'b1,
    localparam int WORD_AW = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_AW-1:0] idx,
    input  logic [LANES-1:0]   wr_lanes,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_word
);
    // each byte starts out holding the low bits of its own byte address
    function automatic logic [DATA_W-1:0] init_word(input int w);
        logic [DATA_W-1:0] r;
        for (int k = 0; k < LANES; k++)
            r[k*LANE_W +: LANE_W] = LANE_W'((BANK_ID * WORDS + w) * LANES + k);
        return r;
    endfunction

    generate
        if (WRITABLE) begin : g_ram
            logic [DATA_W-1:0] mem [WORDS];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int w = 0; w < WORDS; w++) mem[w] <= init_word(w);
                end else begin
                    for (int k = 0; k < LANES; k++)
                        if (wr_lanes[k])
                            mem[idx][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
                end
            end

            assign rd_word = mem[idx];

            for (genvar k = 0; k < LANES; k++) begin : g_wchk
                // R11
                lane_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    wr_lanes[k] |=> mem[$past(idx)][k*LANE_W +: LANE_W] == $past(wdata[k*LANE_W +: LANE_W]));
            end
        end else begin : g_rom
            assign rd_word = init_word(int'(idx));
        end
    endgenerate
endmodule

// File: rtl/bootmem_banked.sv
module bootmem_banked
    import bootmem_pkg::*;
#(
    parameter int NBANK    = 4,
    parameter int WORDS    = 16,
    parameter bit WRITABLE = 1'b1,
    localparam int BANK_AW = $clog2(NBANK),
    localparam int WORD_AW = $clog2(WORDS),
    localparam int ADDR_W  = BANK_AW + WORD_AW + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [1:0]             size,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic                   err,
    output logic [NBANK*LANES-1:0] bus_drive
);
    logic [BANK_AW-1:0] bank_idx;
    logic [WORD_AW-1:0] word_idx;
    logic [LANES-1:0]   lane_en;
    logic               misal;
    logic [NBANK-1:0]   bank_sel;
    logic [DATA_W-1:0]  bank_word [NBANK];
    logic [NBANK-1:0]   lane_col  [LANES];

    assign bank_idx = addr[ADDR_W-1 -: BANK_AW];
    assign word_idx = addr[2 +: WORD_AW];

    bootmem_lane_dec u_dec (
        .offs    (addr[1:0]),
        .size    (size),
        .lane_en (lane_en),
        .misal   (misal)
    );

    always_comb begin
        bank_sel = '0;
        bank_sel[bank_idx] = 1'b1;
    end

    assign err = (rd_en | wr_en) & misal;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic [LANES-1:0] wr_lanes;
            assign wr_lanes = (wr_en && !misal && bank_sel[b]) ? lane_en : '0;
            assign bus_drive[b*LANES +: LANES] =
                (rd_en && !misal && bank_sel[b]) ? lane_en : '0;

            bootmem_bank #(
                .BANK_ID  (b),
                .WORDS    (WORDS),
                .WRITABLE (WRITABLE)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .idx      (word_idx),
                .wr_lanes (wr_lanes),
                .wdata    (wdata),
                .rd_word  (bank_word[b])
            );
        end
    endgenerate

    // AND-OR merge of gated lanes onto the shared bus
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NBANK; b++)
            for (int k = 0; k < LANES; k++)
                rdata[k*LANE_W +: LANE_W] = rdata[k*LANE_W +: LANE_W]
                    | ({LANE_W{bus_drive[b*LANES+k]}} & bank_word[b][k*LANE_W +: LANE_W]);
    end

    always_comb
        for (int k = 0; k < LANES; k++)
            for (int b = 0; b < NBANK; b++)
                lane_col[k][b] = bus_drive[b*LANES+k];

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lchk
            // R9
            lane_one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(lane_col[k]));
        end
    endgenerate

    // R6
    err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (bus_drive == '0 && rdata == '0));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (bus_drive == '0 && rdata == '0));

    // R4
    word_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && size == SZ_WORD && addr[1:0] == 2'b00) |-> $countones(bus_drive) == LANES);

    // R2
    byte_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && size == SZ_BYTE) |-> $countones(bus_drive) == 1);
endmodule

// File: tb/bootmem_banked_test.sv
module bootmem_banked_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic [15:0] bus_drive;

    int total = 0;
    int bad = 0;
    logic [7:0] model [256];

    bootmem_banked uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .size(size), .wdata(wdata), .rdata(rdata), .err(err), .bus_drive(bus_drive)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (addr=%h size=%0d)", req, act, exp, addr, size);
        end
    endtask

    function automatic logic [3:0] exp_lanes(input logic [7:0] a, input logic [1:0] s);
        case (s)
            2'd0: return 4'b0001 << a[1:0];
            2'd1: return a[0] ? 4'b0000 : (a[1] ? 4'b1100 : 4'b0011);
            2'd2: return (a[1:0] == 2'b00) ? 4'b1111 : 4'b0000;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic exp_bad(input logic [7:0] a, input logic [1:0] s);
        case (s)
            2'd0: return 1'b0;
            2'd1: return a[0];
            2'd2: return a[1:0] != 2'b00;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a, input logic [3:0] ln);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++)
            if (ln[k]) r[k*8 +: 8] = model[{a[7:2], 2'(k)}];
        return r;
    endfunction

    task automatic drive(input logic r, input logic w, input logic [7:0] a,
                         input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        rd_en = r; wr_en = w; addr = a; size = s; wdata = d;
        #1;
    endtask

    task automatic read_check(input logic [7:0] a, input logic [1:0] s, input string tag);
        logic [3:0]  ln;
        logic        bd;
        drive(1'b1, 1'b0, a, s, 32'h0);
        ln = exp_lanes(a, s);
        bd = exp_bad(a, s);
        check({tag, " R1 R7 rdata"}, rdata, bd ? 32'h0 : exp_rd(a, ln));
        check("R6 err", {31'h0, err}, {31'h0, bd});
        check("R9 bus_drive", {16'h0, bus_drive}, {16'h0, 16'(ln) << (4 * a[7:6])});
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) model[a] = 8'(a);
        #1;
        // reset state: outputs idle
        check("R8 reset rdata", rdata, 32'h0);
        check("R6 reset err", {31'h0, err}, 32'h0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R10 R2 R3 R4 R5: full sweep of address by size code on reset contents
        for (int a = 0; a < 256; a++)
            for (int s = 0; s < 4; s++)
                read_check(8'(a), 2'(s), s == 0 ? "R2 R10" : s == 1 ? "R3 R10" : s == 2 ? "R4 R10" : "R5 R10");

        // R8: no strobe, any address/size
        for (int a = 0; a < 256; a += 7) begin
            drive(1'b0, 1'b0, 8'(a), 2'(a % 4), 32'h0);
            check("R8 idle rdata", rdata, 32'h0);
            check("R8 idle drive", {16'h0, bus_drive}, 32'h0);
            check("R8 idle err", {31'h0, err}, 32'h0);
        end

        // R11: mixed writes, including misaligned and reserved forms
        for (int i = 0; i < 96; i++) begin
            logic [7:0]  a;
            logic [1:0]  s;
            logic [31:0] d;
            logic [3:0]  ln;
            a = 8'((i * 37 + i / 5) % 256);
            s = 2'((i * 3 + i / 4) % 4);
            d = (32'(i) * 32'h01010101) ^ 32'hC3A50F96;
            drive(1'b0, 1'b1, a, s, d);
            ln = exp_lanes(a, s);
            check("R6 write err", {31'h0, err}, {31'h0, exp_bad(a, s)});
            check("R11 no read drive on write", {16'h0, bus_drive}, 32'h0);
            for (int k = 0; k < 4; k++)
                if (ln[k]) model[{a[7:2], 2'(k)}] = d[k*8 +: 8];
            @(posedge clk);
        end
        // R11 R13: read back whole memory in words
        for (int w = 0; w < 64; w++)
            read_check(8'(w * 4), 2'd2, "R11 R13");

        // R13: write then read in the very next cycle
        drive(1'b0, 1'b1, 8'hB6, 2'd1, 32'h1234ABCD);
        model[8'hB6] = 8'h34; model[8'hB7] = 8'h12;
        read_check(8'hB6, 2'd1, "R13");
        read_check(8'hB4, 2'd2, "R13");

        // R12: reset restores table
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 256; a++) model[a] = 8'(a);
        for (int w = 0; w < 64; w++)
            read_check(8'(w * 4), 2'd2, "R12");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule